// File: doc/BRIEF.md
# Slow Synchronous Peripheral Cycle Bridge

This block sits between a fast bus master that uses an address strobe and byte strobes and an older peripheral that only moves data in step with a slow enable clock. The bridge divides the system clock by ten to make a free-running peripheral clock. That clock is high for four system clocks and low for six. An external address decoder flags a slow access by pulling the valid-peripheral-address input low while the address strobe is low. The bridge then waits for the peripheral clock to reach the start of a low phase. At that point it drives the active-low peripheral enable. The transfer happens during the high phase that follows, and the cycle closes when the peripheral clock falls.

On a read, the bridge captures the peripheral data into a holding register on the edge where the peripheral clock falls. Only the byte lanes whose strobes are active are captured. A one-cycle done flag tells the master that the data is ready. The master must negate the address strobe before the bridge accepts another slow cycle. If the master drops the address strobe while the bridge is still waiting for alignment, the bridge goes back to idle without enabling the peripheral. The peripheral clock is never stopped or re-phased.

Top module: `slow_periph_bridge`

## Requirements
- R1: The peripheral clock `pclk` repeats every DIV system clocks (default 10). In each period it is low for DIV-HIGH clocks (default 6), then high for HIGH clocks (default 4). After reset it starts at the first cycle of a low phase.
- R2: A slow cycle starts only when `as_n` is low, `vpa_n` is low and at least one bit of `strb_n` is low. If any of these is missing, `vma_n` stays high.
- R3: `vma_n` goes low only in the first system clock of a `pclk` low phase. This is the same cycle in which `pclk` has just fallen.
- R4: Once asserted, `vma_n` stays low for DIV+1 system clocks: one full peripheral period plus the done cycle.
- R5: On a read (`rw`=1), each byte lane i whose `strb_n[i]` is low loads `pdata_in[8i+7:8i]` into `rdata` at the edge where `pclk` falls. Lanes whose strobe is high keep their previous value.
- R6: On a write (`rw`=0), `rdata` is not changed.
- R7: `done` is high for exactly one cycle, and this cycle is the one right after data capture. On the next edge, `vma_n` returns high and `done` returns low together.
- R8: If `as_n` goes high while the bridge is waiting for alignment, `vma_n` is never asserted for that request. `pclk` keeps its period and phase.
- R9: After a completed cycle, no new cycle starts until `as_n` has been high for at least one clock, even if `as_n` and `vpa_n` stay low.
- R10: While `rst_n` is low: `vma_n`=1, `done`=0, `pclk`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe from the master, active low |
| rw | input | 1 | 1 = read, 0 = write |
| strb_n | input | DATA_W/8 | Byte lane strobes, active low; bit i covers data bits 8i+7:8i |
| vpa_n | input | 1 | Decoder flag for a slow peripheral address, active low |
| pdata_in | input | DATA_W | Data returned by the peripheral |
| vma_n | output | 1 | Peripheral enable after phase alignment, active low |
| pclk | output | 1 | Free-running peripheral clock, divide by DIV |
| rdata | output | DATA_W | Latched read data |
| done | output | 1 | One-cycle cycle-complete flag |

## Verification
The hardest case to reach from the ports is an abort during alignment. The address strobe has to be released while the bridge is still waiting for the low phase, and before the peripheral clock can fall. To get there, the stimulus first watches `pclk` until it falls. It then raises the request one clock later, which leaves almost a full period of waiting, and withdraws the request after three clocks. The bench then checks that `vma_n` never goes low and that the peripheral clock's period is unchanged. The table-driven cycles start after gaps of different lengths, so that requests arrive at many different phases of `pclk`.

// File: rtl/slowbus_pkg.sv
package slowbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SYNC,
      ST_XFER,
      ST_DONE,
      ST_HOLD
   } bridge_st_t;
endpackage

// File: rtl/sb_pclk_gen.sv
module sb_pclk_gen #(
   parameter int DIV  = 10,
   parameter int HIGH = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic pclk,
   output logic fall_tick
);
   localparam int PW  = $clog2(DIV);
   localparam int LOW = DIV - HIGH;

   logic [PW-1:0] ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ph <= '0;
      else if (ph == PW'(DIV - 1))     ph <= '0;
      else                             ph <= ph + 1'b1;
   end

   assign pclk      = (ph >= PW'(LOW));
   assign fall_tick = (ph == PW'(DIV - 1));

   // run-length counters for checking the waveform shape
   logic [PW:0] hi_run, lo_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= '0;
      end else begin
         hi_run <= pclk ? hi_run + 1'b1 : '0;
         lo_run <= pclk ? '0 : lo_run + 1'b1;
      end
   end

   a_r1_high_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pclk) |-> (hi_run == (PW+1)'(HIGH)));
   a_r1_low_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pclk) |-> (lo_run == (PW+1)'(LOW)));
endmodule

// File: rtl/sb_cycle_fsm.sv
module sb_cycle_fsm
   import slowbus_pkg::*;
#(
   parameter int DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic as_n,
   input  logic vpa_n,
   input  logic any_strb,
   input  logic rw,
   input  logic fall_tick,
   output logic vma_n,
   output logic done,
   output logic capture
);
   localparam int RW_ = $clog2(DIV + 2) + 1;

   bridge_st_t st, st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: if (!as_n && !vpa_n && any_strb) st_nx = ST_SYNC;
         ST_SYNC: if (as_n)           st_nx = ST_IDLE;
                  else if (fall_tick) st_nx = ST_XFER;
         ST_XFER: if (fall_tick)      st_nx = ST_DONE;
         ST_DONE:                     st_nx = ST_HOLD;
         ST_HOLD: if (as_n)           st_nx = ST_IDLE;
         default:                     st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   assign vma_n   = !((st == ST_XFER) || (st == ST_DONE));
   assign done    = (st == ST_DONE);
   assign capture = (st == ST_XFER) && fall_tick && rw;

   logic [RW_-1:0] vma_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vma_run <= '0;
      else if (!vma_n) vma_run <= vma_run + 1'b1;
      else             vma_run <= '0;
   end

   a_r3_vma_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vma_n) |-> $past(fall_tick));
   a_r4_vma_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vma_n) |-> (vma_run == RW_'(DIV + 1)));
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && vma_n));
   a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SYNC && as_n) |=> vma_n);
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD && !as_n) |=> vma_n);
endmodule

// File: rtl/sb_rd_latch.sv
module sb_rd_latch #(
   parameter int DATA_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  capture,
   input  logic [DATA_W/8-1:0]   strb_n,
   input  logic [DATA_W-1:0]     din,
   output logic [DATA_W-1:0]     dout
);
   localparam int LANES = DATA_W / 8;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dout[8*i +: 8] <= '0;
         else if (capture && !strb_n[i])
            dout[8*i +: 8] <= din[8*i +: 8];
      end
   end

   a_r6_no_write_load: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(dout));
endmodule

// File: rtl/slow_periph_bridge.sv
module slow_periph_bridge #(
   parameter int DATA_W = 16,
   parameter int DIV    = 10,
   parameter int HIGH   = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  as_n,
   input  logic                  rw,
   input  logic [DATA_W/8-1:0]   strb_n,
   input  logic                  vpa_n,
   input  logic [DATA_W-1:0]     pdata_in,
   output logic                  vma_n,
   output logic                  pclk,
   output logic [DATA_W-1:0]     rdata,
   output logic                  done
);
   localparam int LANES = DATA_W / 8;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("slow_periph_bridge: DATA_W must be a positive multiple of 8");
   end
   if (DIV < 4) begin : g_bad_div
      $error("slow_periph_bridge: DIV must be at least 4");
   end
   if (HIGH < 1 || HIGH > DIV - 2) begin : g_bad_high
      $error("slow_periph_bridge: HIGH must leave at least two low cycles");
   end

   logic fall_tick, capture;

   sb_pclk_gen #(.DIV(DIV), .HIGH(HIGH)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .pclk      (pclk),
      .fall_tick (fall_tick)
   );

   sb_cycle_fsm #(.DIV(DIV)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .as_n      (as_n),
      .vpa_n     (vpa_n),
      .any_strb  (strb_n != {LANES{1'b1}}),
      .rw        (rw),
      .fall_tick (fall_tick),
      .vma_n     (vma_n),
      .done      (done),
      .capture   (capture)
   );

   sb_rd_latch #(.DATA_W(DATA_W)) u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .strb_n  (strb_n),
      .din     (pdata_in),
      .dout    (rdata)
   );

   a_r2_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      (vma_n && (as_n || vpa_n || strb_n == {LANES{1'b1}}) && !fall_tick) |=> vma_n);
   a_r3_vma_pclk_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vma_n) |-> $fell(pclk));
endmodule

// File: tb/slow_periph_bridge_bench.sv
module slow_periph_bridge_bench;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        as_n = 1, rw = 1, vpa_n = 1;
   logic [1:0]  strb_n = 2'b11;
   logic [15:0] pdata_in = '0;
   logic        vma_n, pclk, done;
   logic [15:0] rdata;

   int total = 0;
   int bad = 0;
   logic [15:0] model = '0;

   always #4 clk = ~clk;

   slow_periph_bridge u_slow_periph_bridge (
      .clk(clk), .rst_n(rst_n), .as_n(as_n), .rw(rw), .strb_n(strb_n),
      .vpa_n(vpa_n), .pdata_in(pdata_in), .vma_n(vma_n), .pclk(pclk),
      .rdata(rdata), .done(done)
   );

   // vector: {rw, strb_n[1:0], pdata[15:0], gap[3:0]}
   localparam int NV = 8;
   localparam logic [22:0] VEC [NV] = '{
      {1'b1, 2'b00, 16'hA55A, 4'd1},
      {1'b1, 2'b10, 16'h1234, 4'd3},
      {1'b1, 2'b01, 16'hBEEF, 4'd7},
      {1'b0, 2'b00, 16'hFFFF, 4'd2},
      {1'b1, 2'b01, 16'h0F0F, 4'd5},
      {1'b0, 2'b10, 16'h0000, 4'd9},
      {1'b1, 2'b00, 16'hC3C3, 4'd0},
      {1'b1, 2'b10, 16'h7E81, 4'd4}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_cycle(input logic r, input logic [1:0] s, input logic [15:0] d, input int gap);
      int  vlow = 0;
      bit  got = 0;
      logic prevp;
      int  late_low = 0;
      repeat (gap + 1) @(posedge clk);
      #1;
      as_n = 0; vpa_n = 0; rw = r; strb_n = s; pdata_in = d;
      if (r) begin
         if (!s[0]) model[7:0]  = d[7:0];
         if (!s[1]) model[15:8] = d[15:8];
      end
      prevp = pclk;
      for (int i = 0; i < 40 && !got; i++) begin
         @(negedge clk);
         if (!vma_n) begin
            if (vlow == 0) begin
               chk("R3 pclk low at vma", 32'(pclk), 32'd0);
               chk("R3 pclk high before vma", 32'(prevp), 32'd1);
            end
            vlow++;
         end
         if (done) begin
            got = 1;
            chk(r ? "R5 read data" : "R6 write keeps data", 32'(rdata), 32'(model));
         end
         prevp = pclk;
      end
      chk("R7 done seen", 32'(got), 32'd1);
      @(negedge clk);
      chk("R7 done released", 32'(done), 32'd0);
      chk("R7 vma released", 32'(vma_n), 32'd1);
      chk("R4 vma length", 32'(vlow), 32'd11);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (!vma_n) late_low++;
      end
      chk("R9 no restart while as_n low", 32'(late_low), 32'd0);
      @(posedge clk); #1;
      as_n = 1; vpa_n = 1; strb_n = 2'b11;
   endtask

   task automatic no_cycle(input string req, input int n);
      int lows = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!vma_n) lows++;
      end
      chk(req, 32'(lows), 32'd0);
   endtask

   task automatic check_period(input string req);
      int hi = 0, lo = 0;
      do @(negedge clk); while (pclk);
      do @(negedge clk); while (!pclk);
      while (pclk) begin hi++; @(negedge clk); end
      while (!pclk) begin lo++; @(negedge clk); end
      chk({req, " high len"}, 32'(hi), 32'd4);
      chk({req, " low len"}, 32'(lo), 32'd6);
   endtask

   initial begin
      #(8 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int lowcnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      chk("R10 vma_n in reset", 32'(vma_n), 32'd1);
      chk("R10 done in reset", 32'(done), 32'd0);
      chk("R10 pclk in reset", 32'(pclk), 32'd0);
      chk("R10 rdata in reset", 32'(rdata), 32'd0);
      @(posedge clk); #1;
      rst_n = 1;
      // R1 first low phase after reset
      @(negedge clk);
      while (!pclk && lowcnt < 20) begin lowcnt++; @(negedge clk); end
      chk("R1 first low phase", 32'(lowcnt), 32'd6);
      check_period("R1");

      for (int v = 0; v < NV; v++)
         run_cycle(VEC[v][22], VEC[v][21:20], VEC[v][19:4], int'(VEC[v][3:0]));

      // R2: missing vpa_n
      @(posedge clk); #1;
      as_n = 0; vpa_n = 1; strb_n = 2'b00; rw = 1;
      no_cycle("R2 vpa_n high", 25);
      // R2: no byte strobe
      @(posedge clk); #1;
      vpa_n = 0; strb_n = 2'b11;
      no_cycle("R2 no strobe", 25);
      // R2: as_n high
      @(posedge clk); #1;
      as_n = 1; strb_n = 2'b00;
      no_cycle("R2 as_n high", 25);
      @(posedge clk); #1;
      vpa_n = 1; strb_n = 2'b11;
      chk("R2 rdata untouched", 32'(rdata), 32'(model));

      // R8: abort during alignment
      do @(negedge clk); while (!pclk);
      do @(negedge clk); while (pclk);
      @(posedge clk); #1;
      as_n = 0; vpa_n = 0; strb_n = 2'b00; rw = 1; pdata_in = 16'h5555;
      repeat (3) @(posedge clk);
      #1;
      as_n = 1; vpa_n = 1; strb_n = 2'b11;
      no_cycle("R8 no vma after abort", 25);
      chk("R8 rdata untouched", 32'(rdata), 32'(model));
      check_period("R8 pclk undisturbed");

      // bridge still works after the abort
      run_cycle(1'b1, 2'b00, 16'h9A9A, 2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule